// File: doc/BRIEF.md
# Serially Programmed PWM Generator

This block turns a system clock into a pulse-width-modulated output whose period and high time are set over a three-wire serial link. The serial pins are plain control inputs with no valid/ready handshake. Every rising serial-clock edge seen while select is low shifts in one data bit. A complete 24-bit frame loads three 8-bit fields at once: high time, period and mode. The serial pins are asynchronous to the system clock. They are synchronised and their edges are detected in the system-clock domain, so the serial clock must run well below the system clock.

The period counter runs on an enable tick. In the normal mode the tick is active on every system clock. In the half-rate mode it is active on every other system clock. In sleep mode there is no tick, so the counters hold. New high-time and period values wait in pending registers and move into the active copies at the end of the running period, so no period is ever cut short. The mode field acts at once. A digital over-threshold input forces the output low without any delay.

Top module: `serial_pwm_gen`

## Requirements
- R1: After reset the output is low, and it stays low until the first complete frame has been received. That first frame takes effect immediately, with the period counter starting at zero.
- R2: A frame is 24 bits, sent MSB first and sampled on rising `sck` edges while `cs_n` is low. Bits 23..16 hold the high time, bits 15..8 the period value and bits 1..0 the mode field.
- R3: A bit counter steps from 0 to 23. The load strobe is issued on the 24th bit, and the counter then wraps to 0.
- R4: If `cs_n` goes high before 24 bits have arrived, the bit counter is cleared and nothing is loaded. The next full frame then loads correctly.
- R5: The period is F ticks, where F is the period field. F = 0 means 256 ticks.
- R6: The output is high for the first W ticks of each period, where W is the high-time field. W = 0 gives a constant low output. W ≥ F (with F ≠ 0) gives a constant high output.
- R7: Mode field 01 selects half rate: the tick is active on alternate clocks, so every timing doubles.
- R8: Mode field 1x selects sleep: the counters hold and the output is low. Mode field 00 is normal rate.
- R9: While `over_thr` is high the output is low in the same cycle, whatever the counter state.
- R10: A new high-time or period value changes the active settings only at a period boundary. The mode field takes effect on load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial bit clock, asynchronous |
| sdata | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low frame select |
| over_thr | input | 1 | Threshold-exceeded flag, forces the output low |
| pwm_out | output | 1 | Modulated output |

## Verification
Corrupt active settings or a broken tick would show at the output within one or two periods. They would appear as a wrong count of high cycles or a wrong count of rising edges over a window that is a whole number of periods long. A mis-stepped bit counter would shift the field boundaries, so the following frame would load skewed values, and the duty cycle would differ as soon as that frame is applied. A fault in the override or in the sleep gating would show as a high output cycle on the very clock where it occurs.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_HALF  = 2'd1,
    MODE_SLEEP = 2'd2
  } pwm_mode_e;

  function automatic pwm_mode_e decode_mode(input logic [1:0] fld);
    if (fld[1])      return MODE_SLEEP;
    else if (fld[0]) return MODE_HALF;
    else             return MODE_RUN;
  endfunction

endpackage

// File: rtl/spwm_frame_rx.sv
module spwm_frame_rx #(
  parameter int REG_W       = 8,
  parameter int NUM_REGS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sck,
  input  logic                        sdata,
  input  logic                        cs_n,
  output logic                        load_o,
  output logic [REG_W*NUM_REGS-1:0]   frame_o
);
  localparam int FRAME_W = REG_W * NUM_REGS;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  // bit 2: sck, bit 1: data, bit 0: select (idle high)
  logic [2:0] sync_q [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 3'b001;
        else        sync_q[g] <= {sck, sdata, cs_n};
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 3'b001;
        else        sync_q[g] <= sync_q[g-1];
    end
  end

  logic sck_s, dat_s, cs_act, sck_prev, rise;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shift_q;
  logic               load_q;

  assign sck_s  = sync_q[SYNC_STAGES-1][2];
  assign dat_s  = sync_q[SYNC_STAGES-1][1];
  assign cs_act = ~sync_q[SYNC_STAGES-1][0];
  assign rise   = sck_s & ~sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      bit_cnt  <= '0;
      shift_q  <= '0;
      load_q   <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      load_q   <= cs_act & rise & (bit_cnt == LAST);
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shift_q <= {shift_q[FRAME_W-2:0], dat_s};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  assign load_o  = load_q;
  assign frame_o = shift_q;

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);
  a_r3_load_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> $past(bit_cnt) == LAST);
  a_r4_abort_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bit_cnt == '0);
endmodule

// File: rtl/spwm_prescale.sv
module spwm_prescale
  import spwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pwm_mode_e mode_i,
  output logic      tick_o
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   phase_q <= 1'b0;
    else if (mode_i == MODE_HALF) phase_q <= ~phase_q;
    else                          phase_q <= 1'b0;

  always_comb begin
    unique case (mode_i)
      MODE_RUN:  tick_o = 1'b1;
      MODE_HALF: tick_o = phase_q;
      default:   tick_o = 1'b0;
    endcase
  end

  a_r7_half_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HALF && tick_o) |=> (!tick_o || mode_i != MODE_HALF));
  a_r8_sleep_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SLEEP) |-> !tick_o);
endmodule

// File: rtl/spwm_core.sv
module spwm_core
  import spwm_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REG_W-1:0] width_i,
  input  logic [REG_W-1:0] period_i,
  input  logic [1:0]       mode_fld_i,
  input  logic             tick_i,
  input  logic             over_thr_i,
  output pwm_mode_e        mode_o,
  output logic             pwm_o
);
  logic             run_q;
  pwm_mode_e        mode_q;
  logic [REG_W-1:0] pend_w, pend_p, act_w, act_p, cnt_q, last;
  logic             boundary;

  assign last     = act_p - 1'b1;   // 0 wraps to 2**REG_W - 1
  assign boundary = run_q & tick_i & (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= MODE_RUN;
      pend_w <= '0;
      pend_p <= '0;
      act_w  <= '0;
      act_p  <= '0;
      cnt_q  <= '0;
    end else begin
      if (load_i) begin
        mode_q <= decode_mode(mode_fld_i);
        pend_w <= width_i;
        pend_p <= period_i;
      end
      if (!run_q) begin
        if (load_i) begin
          run_q <= 1'b1;
          act_w <= width_i;
          act_p <= period_i;
          cnt_q <= '0;
        end
      end else if (tick_i) begin
        if (boundary) begin
          cnt_q <= '0;
          act_w <= load_i ? width_i  : pend_w;
          act_p <= load_i ? period_i : pend_p;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign mode_o = mode_q;
  assign pwm_o  = run_q & (mode_q != MODE_SLEEP) & ~over_thr_i & (cnt_q < act_w);

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !pwm_o);
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && act_p != '0) |-> cnt_q < act_p);
  a_r8_sleep_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLEEP) |-> !pwm_o);
  a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_q == MODE_SLEEP) |=> $stable(cnt_q));
  a_r9_thr_low: assert property (@(posedge clk) disable iff (!rst_n)
    over_thr_i |-> !pwm_o);
  a_r10_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !boundary) |=> ($stable(act_w) && $stable(act_p)));
endmodule

// File: rtl/serial_pwm_gen.sv
module serial_pwm_gen
  import spwm_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic sdata,
  input  logic cs_n,
  input  logic over_thr,
  output logic pwm_out
);
  localparam int NUM_REGS = 3;
  localparam int FRAME_W  = REG_W * NUM_REGS;

  logic               load;
  logic [FRAME_W-1:0] frame;
  logic               tick;
  pwm_mode_e          mode;

  spwm_frame_rx #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdata(sdata), .cs_n(cs_n),
    .load_o(load), .frame_o(frame)
  );

  spwm_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tick_o(tick)
  );

  spwm_core #(.REG_W(REG_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .width_i(frame[FRAME_W-1 -: REG_W]),
    .period_i(frame[FRAME_W-1-REG_W -: REG_W]),
    .mode_fld_i(frame[1:0]),
    .tick_i(tick), .over_thr_i(over_thr),
    .mode_o(mode), .pwm_o(pwm_out)
  );
endmodule

// File: tb/serial_pwm_gen_tb_top.sv
module serial_pwm_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdata = 1'b0, cs_n = 1'b1, over_thr = 1'b0;
  logic pwm_out;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  serial_pwm_gen dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdata(sdata), .cs_n(cs_n),
    .over_thr(over_thr), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int w, input int p, input int m, input int nbits);
    logic [23:0] word;
    word = {w[7:0], p[7:0], 6'd0, m[1:0]};
    @(posedge clk); #1 cs_n = 1'b0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < nbits; i++) begin
      #1 sdata = word[23-i];
      repeat (4) @(posedge clk);
      #1 sck = 1'b1;
      repeat (4) @(posedge clk);
      #1 sck = 1'b0;
    end
    repeat (4) @(posedge clk);
    #1 cs_n = 1'b1;
    repeat (8) @(posedge clk);
  endtask

  task automatic measure(input int len, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk); prev = pwm_out;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  // program, let the old period drain, then observe two whole periods
  task automatic run_cfg(input int w, input int p, input int m, input string tag);
    int per, div, weff, h, r;
    send(w, p, m, 24);
    repeat (600) @(posedge clk);
    per  = (p == 0) ? 256 : p;
    div  = (m == 1) ? 2 : 1;
    weff = (w < per) ? w : per;
    measure(2 * per * div, h, r);
    check({tag, " high cycles"}, h, 2 * weff * div);
    check({tag, " rising edges"}, r, (w > 0 && w < per) ? 2 : 0);
  endtask

  initial begin
    int h, r;
    int plist [4] = '{1, 3, 7, 0};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: low after reset, before any frame
    measure(300, h, r);
    check("R1 idle highs", h, 0);
    // R2 R3 R5 R6 R7 R10: sweep of period, high time and rate
    for (int m = 0; m < 2; m++)
      for (int pi = 0; pi < 4; pi++) begin
        int per;
        int wl [5];
        per = (plist[pi] == 0) ? 256 : plist[pi];
        wl = '{0, 1, per - 1, per, 255};
        for (int wi = 0; wi < 5; wi++)
          run_cfg(wl[wi] % 256, plist[pi], m, m ? "R7 R5 R6" : "R2 R5 R6 R10");
      end
    // R4: aborted frame loads nothing, next frame aligns
    run_cfg(2, 5, 0, "R4 base");
    send(4, 5, 0, 12);
    repeat (600) @(posedge clk);
    measure(10, h, r);
    check("R4 abort ignored highs", h, 4);
    run_cfg(3, 5, 0, "R4 R3 next frame");
    // R8: sleep holds output low
    send(3, 5, 2, 24);
    repeat (50) @(posedge clk);
    measure(200, h, r);
    check("R8 sleep highs", h, 0);
    check("R8 sleep rises", r, 0);
    send(3, 5, 3, 24);
    measure(200, h, r);
    check("R8 sleep 11 highs", h, 0);
    run_cfg(3, 5, 0, "R8 wake");
    // R9: threshold override forces low at once
    run_cfg(4, 5, 0, "R9 base");
    @(posedge clk); #1 over_thr = 1'b1;
    #1 check("R9 immediate low", int'(pwm_out), 0);
    measure(100, h, r);
    check("R9 override highs", h, 0);
    @(posedge clk); #1 over_thr = 1'b0;
    measure(10, h, r);
    check("R9 release highs", h, 8);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule